// File: doc/BRIEF.md
# DMA Control Register and Interrupt Unit

This block holds the software-visible registers of a memory-to-memory copy engine and sequences each copy. Software programs a source address, a destination address and a control word through a 32-bit register port. When a control write both enables the engine and sets the trigger, the block starts a data-mover back end with a one-cycle start pulse. It then waits for the back end to report how many bytes it moved, or that a memory access failed.

After a successful copy, completion is held back by a programmable number of clock cycles per 32-bit word moved. This gives software the timing it expects from a real copy. Completion clears the trigger and the size field and sets the transfer-complete flag. It can also raise a level interrupt, which stays high until software writes zero to the transfer-complete flag.

The register port uses a word index: index 0 is byte offset 0x00, index 1 is 0x04, index 2 is 0x08 and index 3 is 0x0C.

Top module: `dma_ctrl_regs`

## Requirements
- R1: After reset the control word, source and destination read 0, the delay register reads 4, and irq and mv_start are low.
- R2: Source (index 1), destination (index 2) and per-word delay (index 3, low DLY_W bits, upper bits read 0) read back what was written. The control word (index 0) reads enable at bit 31, trigger at 30, interrupt enable at 29, complete at 28, gather mode at 27, error at 26, size in words at 15:0, and 0 in bits 25:16.
- R3: While idle, a control write with bits 31 and 30 both 1 raises mv_start for exactly the following cycle. mv_words then carries the written size, mv_gather carries bit 27, and mv_src and mv_dst carry the address registers.
- R4: A control write with bit 30 set and bit 31 clear starts nothing. The trigger bit still reads back as written.
- R5: From launch until completion or failure, trigger writes start nothing and leave the trigger bit unchanged.
- R6: In linear mode (bit 27 = 0) the word count is the launched size. Completion happens delay*words cycles after the cycle in which mv_done is sampled, and at least one cycle after it.
- R7: In gather mode (bit 27 = 1) the word count is mv_bytes divided by 4, rounded down.
- R8: At completion the trigger reads 0, the size reads 0 and transfer-complete reads 1. The other control bits keep their values.
- R9: At completion irq goes high only if bit 29 is 1 at that moment. Otherwise irq stays low.
- R10: A control write with bit 28 = 0 clears transfer-complete and drops irq. A write with bit 28 = 1 changes neither. A write of 0 while the bit is already clear changes nothing.
- R11: mv_done together with mv_fail abandons the copy. Transfer-complete stays 0, irq stays low, bit 26 becomes 1, and the engine returns to idle so a new launch is accepted.
- R12: Bit 26 is cleared by a control write with bit 26 = 0. Writing 1 to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe |
| bus_word | input | 2 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at bus_word |
| mv_start | output | 1 | One-cycle start pulse to the back end |
| mv_src | output | 32 | Source address |
| mv_dst | output | 32 | Destination address |
| mv_words | output | 16 | Launched size in 32-bit words |
| mv_gather | output | 1 | Gather mode for the launched copy |
| mv_done | input | 1 | Back end finished (one cycle) |
| mv_fail | input | 1 | Qualifies mv_done as a memory access failure |
| mv_bytes | input | BCNT_W | Bytes actually moved, valid with mv_done |
| irq | output | 1 | Level completion interrupt |

## Verification
Completion timing is measured with three linear sizes (3, 4 and 0 words) and two delay settings. This separates a wrong multiplier, an off-by-one in the countdown and a missing minimum of one cycle. A gather copy reports a byte count that does not match the programmed size and is not a multiple of four. This shows whether the word count comes from the back end and is rounded down. Other runs cover a failed copy followed by a good one, a trigger without enable, a trigger repeated while busy, and acknowledge writes of both polarities. A reference model compares the start pulse, the interrupt and the addressed register on every cycle.

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs #(
  parameter int DLY_W   = 8,
  parameter int BCNT_W  = 18,
  parameter int DLY_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [1:0]        bus_word,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mv_start,
  output logic [31:0]       mv_src,
  output logic [31:0]       mv_dst,
  output logic [15:0]       mv_words,
  output logic              mv_gather,
  input  logic              mv_done,
  input  logic              mv_fail,
  input  logic [BCNT_W-1:0] mv_bytes,
  output logic              irq
);
  localparam int WORDS_W = (BCNT_W - 2 > 16) ? BCNT_W - 2 : 16;
  localparam int CNT_W   = DLY_W + WORDS_W;

  typedef enum logic [1:0] {S_IDLE, S_MOVE, S_WAIT} st_t;

  st_t               st_q;
  logic              en_q, trig_q, ie_q, tc_q, sg_q, err_q, posted_q;
  logic [15:0]       size_q, len_q;
  logic              gat_q, start_q;
  logic [31:0]       src_q, dst_q;
  logic [DLY_W-1:0]  dly_q;
  logic [CNT_W-1:0]  cnt_q;

  wire ctrl_wr = bus_wen && (bus_word == 2'd0);
  wire launch  = ctrl_wr && (st_q == S_IDLE) && bus_wdata[31] && bus_wdata[30];
  wire finish  = (st_q == S_WAIT) && (cnt_q <= CNT_W'(1));
  wire failed  = (st_q == S_MOVE) && mv_done && mv_fail;

  wire [WORDS_W-1:0] words = gat_q ? WORDS_W'(mv_bytes >> 2) : WORDS_W'(len_q);
  wire [CNT_W-1:0]   total = CNT_W'(words) * CNT_W'(dly_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; trig_q <= 1'b0; ie_q <= 1'b0; tc_q <= 1'b0;
      sg_q <= 1'b0; err_q <= 1'b0; posted_q <= 1'b0; size_q <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= bus_wdata[31];
        ie_q   <= bus_wdata[29];
        sg_q   <= bus_wdata[27];
        size_q <= bus_wdata[15:0];
        if (st_q == S_IDLE) trig_q <= bus_wdata[30];
        if (!bus_wdata[28]) begin
          tc_q     <= 1'b0;
          posted_q <= 1'b0;
        end
        if (!bus_wdata[26]) err_q <= 1'b0;
      end
      if (failed) err_q <= 1'b1;
      if (finish) begin
        trig_q <= 1'b0;
        size_q <= '0;
        tc_q   <= 1'b1;
        if (ie_q) posted_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; start_q <= 1'b0; len_q <= '0; gat_q <= 1'b0;
    end else begin
      start_q <= launch;
      case (st_q)
        S_IDLE: if (launch) begin
          st_q  <= S_MOVE;
          len_q <= bus_wdata[15:0];
          gat_q <= bus_wdata[27];
        end
        S_MOVE: if (mv_done) begin
          if (mv_fail) st_q <= S_IDLE;
          else begin
            st_q  <= S_WAIT;
            cnt_q <= total;
          end
        end
        S_WAIT: if (cnt_q <= CNT_W'(1)) st_q <= S_IDLE;
                else cnt_q <= cnt_q - CNT_W'(1);
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; dly_q <= DLY_W'(DLY_RST);
    end else if (bus_wen) begin
      case (bus_word)
        2'd1: src_q <= bus_wdata;
        2'd2: dst_q <= bus_wdata;
        2'd3: dly_q <= bus_wdata[DLY_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_word)
      2'd0:    bus_rdata = {en_q, trig_q, ie_q, tc_q, sg_q, err_q, 10'b0, size_q};
      2'd1:    bus_rdata = src_q;
      2'd2:    bus_rdata = dst_q;
      default: bus_rdata = 32'(dly_q);
    endcase
  end

  assign mv_start  = start_q;
  assign mv_src    = src_q;
  assign mv_dst    = dst_q;
  assign mv_words  = len_q;
  assign mv_gather = gat_q;
  assign irq       = posted_q;
endmodule

// File: rtl/dma_ctrl_regs_chk.sv
module dma_ctrl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wen,
  input logic [1:0]  bus_word,
  input logic [31:0] bus_wdata,
  input logic        mv_start,
  input logic        mv_done,
  input logic        mv_fail,
  input logic        irq,
  input logic        tc_q,
  input logic        ie_q
);
  logic pend;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= 1'b0;
    else if (mv_start) pend <= 1'b1;
    else if (mv_done) pend <= 1'b0;

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |=> !mv_start); // R3
  AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |-> !pend); // R5
  AST_NO_EN_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_word == 2'd0 && bus_wdata[30] && !bus_wdata[31]) |=> !mv_start); // R4
  AST_IRQ_WITH_TC: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tc_q); // R10
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ie_q)); // R9
  AST_ACK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_wen && bus_word == 2'd0 && !bus_wdata[28])); // R10
  AST_FAIL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_done && mv_fail) |=> !$rose(tc_q)); // R11
endmodule

bind dma_ctrl_regs dma_ctrl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_word(bus_word),
  .bus_wdata(bus_wdata), .mv_start(mv_start), .mv_done(mv_done),
  .mv_fail(mv_fail), .irq(irq), .tc_q(tc_q), .ie_q(ie_q)
);

// File: tb/sim_dma_ctrl_regs.sv
`timescale 1ns/1ps
module sim_dma_ctrl_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wen = 1'b0;
  logic [1:0] bus_word = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, mv_src, mv_dst;
  logic mv_start, mv_gather, irq;
  logic [15:0] mv_words;
  logic mv_done = 1'b0, mv_fail = 1'b0;
  logic [17:0] mv_bytes = '0;

  int nchk = 0, nfail = 0;
  bit running = 1'b0;

  always #4 clk = ~clk;

  dma_ctrl_regs u0 (.*);

  // behavioural reference model
  bit m_en, m_trig, m_ie, m_tc, m_sg, m_err, m_irq, m_start, m_gat;
  int m_size, m_len, m_src, m_dst, m_dly, m_state, m_cnt;

  always @(posedge clk) begin : model
    int os, dly_old;
    bit fin, ie_old;
    if (!rst_n) begin
      m_en = 0; m_trig = 0; m_ie = 0; m_tc = 0; m_sg = 0; m_err = 0; m_irq = 0;
      m_start = 0; m_gat = 0; m_size = 0; m_len = 0; m_src = 0; m_dst = 0;
      m_dly = 4; m_state = 0; m_cnt = 0;
    end else begin
      os = m_state; ie_old = m_ie; dly_old = m_dly; m_start = 0;
      fin = (os == 2) && (m_cnt <= 1);
      if (bus_wen) begin
        if (bus_word == 0) begin
          m_en = bus_wdata[31]; m_ie = bus_wdata[29]; m_sg = bus_wdata[27];
          m_size = bus_wdata[15:0];
          if (os == 0) m_trig = bus_wdata[30];
          if (!bus_wdata[28]) begin m_tc = 0; m_irq = 0; end
          if (!bus_wdata[26]) m_err = 0;
          if (os == 0 && bus_wdata[31] && bus_wdata[30]) begin
            m_state = 1; m_start = 1; m_len = bus_wdata[15:0]; m_gat = bus_wdata[27];
          end
        end
        else if (bus_word == 1) m_src = bus_wdata;
        else if (bus_word == 2) m_dst = bus_wdata;
        else m_dly = bus_wdata[7:0];
      end
      if (os == 1 && mv_done) begin
        if (mv_fail) begin m_err = 1; m_state = 0; end
        else begin m_cnt = (m_gat ? mv_bytes / 4 : m_len) * dly_old; m_state = 2; end
      end
      if (os == 2) begin
        if (fin) begin
          m_state = 0; m_trig = 0; m_size = 0; m_tc = 1;
          if (ie_old) m_irq = 1;
        end else m_cnt = m_cnt - 1;
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [1:0] w);
    case (w)
      2'd0: return {m_en, m_trig, m_ie, m_tc, m_sg, m_err, 10'b0, 16'(m_size)};
      2'd1: return m_src;
      2'd2: return m_dst;
      default: return m_dly;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (running) begin
      check("R3 mv_start per cycle", 32'(mv_start), 32'(m_start));
      check("R9 irq per cycle", 32'(irq), 32'(m_irq));
      check("R2 read per cycle", bus_rdata, m_read(bus_word));
    end
  end

  task automatic step; @(negedge clk); #1; endtask

  task automatic wr(input logic [1:0] w, input logic [31:0] d);
    step; bus_wen = 1'b1; bus_word = w; bus_wdata = d;
    step; bus_wen = 1'b0; bus_word = 2'd0;
  endtask

  task automatic rd(input logic [1:0] w, output logic [31:0] d);
    step; bus_word = w; #1; d = bus_rdata;
  endtask

  task automatic wait_start(input string req);
    int n = 0;
    while (mv_start !== 1'b1 && n < 20) begin step; n++; end
    check(req, 32'(mv_start), 32'd1);
  endtask

  // pulse done, return cycles until transfer-complete reads 1
  task automatic finish_copy(input int bytes, input bit fail, output int k);
    step; mv_done = 1'b1; mv_bytes = 18'(bytes); mv_fail = fail; bus_word = 2'd0;
    step; mv_done = 1'b0; mv_fail = 1'b0;
    k = 1; #1;
    while (bus_rdata[28] !== 1'b1 && k < 200) begin step; #1; k++; end
  endtask

  initial begin
    #800000;
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    // R1 reset state
    rd(0, v); check("R1 ctrl", v, 32'h0);
    rd(1, v); check("R1 src", v, 32'h0);
    rd(2, v); check("R1 dst", v, 32'h0);
    rd(3, v); check("R1 delay", v, 32'd4);
    check("R1 irq", 32'(irq), 32'd0);
    // R2 readback
    wr(1, 32'h0001_1000); wr(2, 32'h0002_2000);
    rd(1, v); check("R2 src", v, 32'h0001_1000);
    rd(2, v); check("R2 dst", v, 32'h0002_2000);
    // R4 trigger without enable
    wr(0, 32'h4000_0005);
    repeat (4) step;
    check("R4 no start", 32'(mv_start), 32'd0);
    rd(0, v); check("R4 trig stored", v, 32'h4000_0005);
    wr(0, 32'h0);
    // R3 launch, R5 retrigger, R6 timing, R8, R9
    wr(0, 32'hE000_0003);
    wait_start("R3 start");
    check("R3 words", 32'(mv_words), 32'd3);
    check("R3 src", mv_src, 32'h0001_1000);
    check("R3 dst", mv_dst, 32'h0002_2000);
    check("R3 gather", 32'(mv_gather), 32'd0);
    wr(0, 32'hE000_0003);
    repeat (3) step;
    check("R5 no relaunch", 32'(mv_start), 32'd0);
    finish_copy(12, 1'b0, k);
    check("R6 delay 3x4", 32'(k), 32'd13);
    rd(0, v); check("R8 ctrl after completion", v, 32'hB000_0000);
    check("R9 irq raised", 32'(irq), 32'd1);
    // R10 acknowledge
    wr(0, 32'hB000_0000);
    rd(0, v); check("R10 write1 ignored", v, 32'hB000_0000);
    check("R10 irq held", 32'(irq), 32'd1);
    wr(0, 32'hA000_0000);
    rd(0, v); check("R10 tc cleared", v, 32'hA000_0000);
    check("R10 irq dropped", 32'(irq), 32'd0);
    wr(0, 32'hA000_0000);
    rd(0, v); check("R10 clear when clear", v, 32'hA000_0000);
    // R9 no interrupt enable, R6 with delay 2
    wr(3, 32'd2);
    wr(0, 32'hC000_0004);
    wait_start("R3 start 2");
    finish_copy(16, 1'b0, k);
    check("R6 delay 4x2", 32'(k), 32'd9);
    check("R9 no irq without enable", 32'(irq), 32'd0);
    wr(0, 32'h8000_0000);
    // R6 zero size
    wr(0, 32'hC000_0000);
    wait_start("R3 start 3");
    finish_copy(0, 1'b0, k);
    check("R6 zero words one cycle", 32'(k), 32'd2);
    wr(0, 32'h8000_0000);
    // R7 gather mode
    wr(3, 32'd3);
    wr(0, 32'hE800_0007);
    wait_start("R3 start 4");
    check("R7 gather flag", 32'(mv_gather), 32'd1);
    finish_copy(22, 1'b0, k);
    check("R7 gather 5 words x3", 32'(k), 32'd16);
    check("R9 irq gather", 32'(irq), 32'd1);
    wr(0, 32'h8000_0000);
    check("R10 irq ack", 32'(irq), 32'd0);
    // R11 failure
    wr(0, 32'hE000_0002);
    wait_start("R3 start 5");
    step; mv_done = 1'b1; mv_fail = 1'b1;
    step; mv_done = 1'b0; mv_fail = 1'b0;
    repeat (10) step;
    rd(0, v);
    check("R11 no tc", 32'(v[28]), 32'd0);
    check("R11 err set", 32'(v[26]), 32'd1);
    check("R11 no irq", 32'(irq), 32'd0);
    // R12 error bit
    wr(0, 32'h8400_0000);
    rd(0, v); check("R12 write1 keeps", 32'(v[26]), 32'd1);
    wr(0, 32'h8000_0000);
    rd(0, v); check("R12 write0 clears", 32'(v[26]), 32'd0);
    // R11 idle again
    wr(0, 32'hC000_0001);
    wait_start("R11 relaunch");
    finish_copy(4, 1'b0, k);
    check("R11 good copy after fail", 32'(k), 32'd4);
    repeat (4) step;
    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule